// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Engine

This block services one USB data transaction at a time against a buffer descriptor taken from a small register-mapped descriptor store. The store holds one descriptor per endpoint and direction. Software fills a descriptor, sets its ownership flag and leaves it to the engine. When the protocol side presents a token, the engine reads that endpoint's descriptor. If the engine does not own it, the token is refused with a one-cycle NAK pulse. Otherwise the engine runs the transaction.

For an IN token the engine streams the programmed number of bytes out of the buffer through a combinational memory read port, with the DATA PID chosen by the descriptor's toggle bit. For an OUT token it takes a PID strobe, then byte strobes, then an end strobe. Accepted bytes go through a memory write port. When checking is enabled, a packet with the wrong toggle is discarded.

At the end of the transaction the engine writes the actual byte count and the PID back into the descriptor, clears its ownership flag and pulses a completion event. Keep mode, no-increment addressing and toggle checking each change this flow. Byte-count overflow on OUT is held on a sticky error output.

Top module: `bd_engine`

## Requirements
- R1: After reset, every descriptor word reads 0, ovf_o is 0, and none of tx_valid_o, tx_end_o, mem_we_o, ack_o, nak_o or done_o is asserted.
- R2: A token for a descriptor whose word 0 bit 7 (owner flag) is 0 produces exactly one nak_o pulse in the cycle after the token. It causes no byte transfer, no memory write and no completion event, and it leaves the descriptor unchanged.
- R3: An IN token on an owned descriptor emits exactly N bytes on tx_valid_o/tx_data_o, where N is word 0 bits 25:16. The bytes are read from consecutive addresses starting at word 1. tx_pid_o is 4'b1011 (DATA1) when word 0 bit 6 is 1 and 4'b0011 (DATA0) otherwise. One tx_end_o pulse follows, including when N is 0.
- R4: When word 0 bit 4 (hold address) is 1, every byte of the transaction, IN or OUT, uses the word 1 address unchanged.
- R5: An accepted OUT packet stores its bytes in arrival order at consecutive addresses from word 1. Word 0 is then rewritten with the stored count in bits 25:16, the received PID in bits 5:2 and bit 7 cleared. Bit 6 is kept and all other bits are kept.
- R6: When word 0 bit 3 (toggle check) is 1 and the received PID is not the one selected by bit 6, the packet makes no memory write. The descriptor is left unchanged, no done_o pulse occurs, and ack_o still pulses once.
- R7: When word 0 bit 3 is 0, an OUT packet is accepted whatever its PID.
- R8: When word 0 bit 5 (keep) is 1, bytes still move but the descriptor is not rewritten and no done_o pulse occurs, so a further token on it is serviced again.
- R9: OUT bytes arriving beyond the byte count are dropped. The written-back count equals the byte count, and ovf_o rises and stays at 1 until reset.
- R10: done_o is a one-cycle pulse raised only when ownership is released. done_ep_o and done_in_o (1 = IN) carry the endpoint and direction of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor store write strobe |
| cfg_addr_i | input | EP_W+2 | Descriptor word select {endpoint, in, word} |
| cfg_wdata_i | input | 32 | Descriptor write data |
| cfg_rdata_o | output | 32 | Descriptor read data (combinational) |
| tok_valid_i | input | 1 | Token strobe |
| tok_ep_i | input | EP_W | Token endpoint number |
| tok_in_i | input | 1 | Token direction, 1 = IN |
| rx_pid_valid_i | input | 1 | Received data PID strobe |
| rx_pid_i | input | 4 | Received data PID |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_end_i | input | 1 | End of received packet |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_pid_o | output | 4 | Data PID for the transmitted packet |
| tx_end_o | output | 1 | End of transmitted packet |
| mem_raddr_o | output | 32 | Buffer read address |
| mem_rdata_i | input | 8 | Buffer read data, same cycle |
| mem_we_o | output | 1 | Buffer write enable |
| mem_waddr_o | output | 32 | Buffer write address |
| mem_wdata_o | output | 8 | Buffer write data |
| ack_o | output | 1 | OUT packet handled pulse |
| nak_o | output | 1 | Token refused pulse |
| done_o | output | 1 | Transaction complete, descriptor released |
| done_ep_o | output | EP_W | Endpoint of the completed transaction |
| done_in_o | output | 1 | Direction of the completed transaction |
| ovf_o | output | 1 | Sticky OUT overflow |

## Verification
The assertions assume the protocol side follows a fixed order. A token arrives only while the engine is idle. On OUT, the PID strobe comes before any byte strobe, byte strobes and the end strobe never coincide, and software does not rewrite a descriptor while the engine holds it. The bench drives each transaction in that order, one strobe per cycle. It waits for the completion cycle to pass before the next token or descriptor write, so the address-hold, pulse-width and release properties are only exercised inside legal sequences.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;

  localparam int OWN_BIT  = 7;
  localparam int TOG_BIT  = 6;
  localparam int KEEP_BIT = 5;
  localparam int HOLD_BIT = 4;
  localparam int CHK_BIT  = 3;
  localparam int CNT_LSB  = 16;
  localparam int CNT_W    = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_FIN
  } xfer_state_e;
endpackage

// File: rtl/bd_regfile.sv
module bd_regfile #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W:0]   cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_ctl_o,
  output logic [31:0]      rd_addr_o,
  input  logic             wb_we_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic [31:0]      wb_data_i
);
  import bd_pkg::*;

  localparam int NUM_DESC = 2 ** IDX_W;

  logic [31:0] ctl_q [NUM_DESC];
  logic [31:0] buf_q [NUM_DESC];

  logic [IDX_W-1:0] cfg_idx;
  assign cfg_idx = cfg_addr_i[IDX_W:1];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    // engine write-back wins over software
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[g] <= '0;
      end else if (wb_we_i && wb_idx_i == IDX_W'(g)) begin
        ctl_q[g] <= wb_data_i;
      end else if (cfg_we_i && cfg_idx == IDX_W'(g) && !cfg_addr_i[0]) begin
        ctl_q[g] <= cfg_wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= '0;
      end else if (cfg_we_i && cfg_idx == IDX_W'(g) && cfg_addr_i[0]) begin
        buf_q[g] <= cfg_wdata_i;
      end
    end
  end

  assign cfg_rdata_o = cfg_addr_i[0] ? buf_q[cfg_idx] : ctl_q[cfg_idx];
  assign rd_ctl_o    = ctl_q[rd_idx_i];
  assign rd_addr_o   = buf_q[rd_idx_i];

  AST_WB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_i |-> !wb_data_i[OWN_BIT]); // R5
endmodule

// File: rtl/bd_xfer.sv
module bd_xfer #(
  parameter int EP_W = 2,
  localparam int IDX_W = EP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  input  logic [EP_W-1:0]  tok_ep_i,
  input  logic             tok_in_i,
  input  logic             rx_pid_valid_i,
  input  logic [3:0]       rx_pid_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_end_i,
  input  logic [31:0]      rd_ctl_i,
  input  logic [31:0]      rd_addr_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wb_we_o,
  output logic [IDX_W-1:0] wb_idx_o,
  output logic [31:0]      wb_data_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic [3:0]       tx_pid_o,
  output logic             tx_end_o,
  output logic [31:0]      mem_raddr_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             mem_we_o,
  output logic [31:0]      mem_waddr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             ack_o,
  output logic             nak_o,
  output logic             done_o,
  output logic [EP_W-1:0]  done_ep_o,
  output logic             done_in_o,
  output logic             ovf_o
);
  import bd_pkg::*;

  xfer_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      ctl_q;
  logic [31:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       pid_q;
  logic             mism_q;
  logic             ovf_q;
  logic             nak_q;

  logic [CNT_W-1:0] limit;
  logic             dir_in;
  logic             room;
  logic [31:0]      addr_step;
  logic [3:0]       exp_pid;
  logic             commit;

  assign limit     = ctl_q[CNT_LSB +: CNT_W];
  assign dir_in    = idx_q[0];
  assign room      = cnt_q < limit;
  assign addr_step = ctl_q[HOLD_BIT] ? 32'd0 : 32'd1;
  assign exp_pid   = ctl_q[TOG_BIT] ? PID_DATA1 : PID_DATA0;
  assign rd_idx_o  = (state_q == ST_IDLE) ? {tok_ep_i, tok_in_i} : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ctl_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      pid_q   <= '0;
      mism_q  <= 1'b0;
      ovf_q   <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      nak_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tok_valid_i) begin
            if (rd_ctl_i[OWN_BIT]) begin
              idx_q   <= {tok_ep_i, tok_in_i};
              ctl_q   <= rd_ctl_i;
              addr_q  <= rd_addr_i;
              cnt_q   <= '0;
              mism_q  <= 1'b0;
              pid_q   <= rd_ctl_i[TOG_BIT] ? PID_DATA1 : PID_DATA0;
              state_q <= ST_XFER;
            end else begin
              nak_q <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (dir_in) begin
            if (room) begin
              cnt_q  <= cnt_q + 1'b1;
              addr_q <= addr_q + addr_step;
            end else begin
              state_q <= ST_FIN;
            end
          end else begin
            if (rx_pid_valid_i) begin
              pid_q  <= rx_pid_i;
              mism_q <= ctl_q[CHK_BIT] && (rx_pid_i != exp_pid);
            end
            if (rx_valid_i && !mism_q) begin
              if (room) begin
                cnt_q  <= cnt_q + 1'b1;
                addr_q <= addr_q + addr_step;
              end else begin
                ovf_q <= 1'b1;
              end
            end
            if (rx_end_i) state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid_o  = (state_q == ST_XFER) && dir_in && room;
  assign tx_data_o   = mem_rdata_i;
  assign tx_pid_o    = pid_q;
  assign mem_raddr_o = addr_q;

  assign mem_we_o    = (state_q == ST_XFER) && !dir_in && rx_valid_i && !mism_q && room;
  assign mem_waddr_o = addr_q;
  assign mem_wdata_o = rx_data_i;

  assign commit    = (state_q == ST_FIN) && !ctl_q[KEEP_BIT] && !mism_q;
  assign wb_we_o   = commit;
  assign wb_idx_o  = idx_q;
  assign wb_data_o = {ctl_q[31:26], cnt_q, ctl_q[15:8], 1'b0, ctl_q[TOG_BIT], pid_q, ctl_q[1:0]};

  assign done_o    = commit;
  assign done_ep_o = idx_q[IDX_W-1:1];
  assign done_in_o = idx_q[0];
  assign ack_o     = (state_q == ST_FIN) && !dir_in;
  assign tx_end_o  = (state_q == ST_FIN) && dir_in;
  assign nak_o     = nak_q;
  assign ovf_o     = ovf_q;

  AST_NAK_AFTER_TOK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_o |-> $past(tok_valid_i)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && $past(state_q) == ST_XFER && ctl_q[HOLD_BIT])
      |-> addr_q == $past(addr_q)); // R4
endmodule

// File: rtl/bd_engine.sv
module bd_engine #(
  parameter int EP_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [EP_W+1:0] cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic            tok_valid_i,
  input  logic [EP_W-1:0] tok_ep_i,
  input  logic            tok_in_i,
  input  logic            rx_pid_valid_i,
  input  logic [3:0]      rx_pid_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_end_i,
  output logic            tx_valid_o,
  output logic [7:0]      tx_data_o,
  output logic [3:0]      tx_pid_o,
  output logic            tx_end_o,
  output logic [31:0]     mem_raddr_o,
  input  logic [7:0]      mem_rdata_i,
  output logic            mem_we_o,
  output logic [31:0]     mem_waddr_o,
  output logic [7:0]      mem_wdata_o,
  output logic            ack_o,
  output logic            nak_o,
  output logic            done_o,
  output logic [EP_W-1:0] done_ep_o,
  output logic            done_in_o,
  output logic            ovf_o
);
  localparam int IDX_W = EP_W + 1;

  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      rd_ctl;
  logic [31:0]      rd_addr;
  logic             wb_we;
  logic [IDX_W-1:0] wb_idx;
  logic [31:0]      wb_data;

  bd_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .rd_idx_i    (rd_idx),
    .rd_ctl_o    (rd_ctl),
    .rd_addr_o   (rd_addr),
    .wb_we_i     (wb_we),
    .wb_idx_i    (wb_idx),
    .wb_data_i   (wb_data)
  );

  bd_xfer #(.EP_W(EP_W)) u_xfer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tok_valid_i    (tok_valid_i),
    .tok_ep_i       (tok_ep_i),
    .tok_in_i       (tok_in_i),
    .rx_pid_valid_i (rx_pid_valid_i),
    .rx_pid_i       (rx_pid_i),
    .rx_valid_i     (rx_valid_i),
    .rx_data_i      (rx_data_i),
    .rx_end_i       (rx_end_i),
    .rd_ctl_i       (rd_ctl),
    .rd_addr_i      (rd_addr),
    .rd_idx_o       (rd_idx),
    .wb_we_o        (wb_we),
    .wb_idx_o       (wb_idx),
    .wb_data_o      (wb_data),
    .tx_valid_o     (tx_valid_o),
    .tx_data_o      (tx_data_o),
    .tx_pid_o       (tx_pid_o),
    .tx_end_o       (tx_end_o),
    .mem_raddr_o    (mem_raddr_o),
    .mem_rdata_i    (mem_rdata_i),
    .mem_we_o       (mem_we_o),
    .mem_waddr_o    (mem_waddr_o),
    .mem_wdata_o    (mem_wdata_o),
    .ack_o          (ack_o),
    .nak_o          (nak_o),
    .done_o         (done_o),
    .done_ep_o      (done_ep_o),
    .done_in_o      (done_in_o),
    .ovf_o          (ovf_o)
  );
endmodule

// File: tb/bd_engine_test.sv
module bd_engine_test;
  localparam logic [3:0] D0 = 4'b0011;
  localparam logic [3:0] D1 = 4'b1011;

  typedef struct packed {
    logic       dir_in;
    logic [1:0] ep;
    logic [9:0] cnt;
    logic [7:0] addr;
    logic       tog;
    logic       hold;
    logic       chk;
    logic       keep;
    logic [3:0] rpid;
    logic [9:0] nrx;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 10'd4, 8'd10,  1'b0, 1'b0, 1'b0, 1'b0, D0, 10'd0}, // R3
    '{1'b1, 2'd2, 10'd3, 8'd40,  1'b1, 1'b1, 1'b0, 1'b0, D0, 10'd0}, // R4
    '{1'b1, 2'd0, 10'd0, 8'd60,  1'b1, 1'b0, 1'b0, 1'b0, D0, 10'd0}, // R3 zero length
    '{1'b1, 2'd3, 10'd2, 8'd80,  1'b0, 1'b0, 1'b0, 1'b1, D0, 10'd0}, // R8
    '{1'b0, 2'd1, 10'd5, 8'd100, 1'b0, 1'b0, 1'b1, 1'b0, D0, 10'd4}, // R5
    '{1'b0, 2'd2, 10'd4, 8'd120, 1'b1, 1'b0, 1'b1, 1'b0, D0, 10'd3}, // R6
    '{1'b0, 2'd0, 10'd4, 8'd140, 1'b0, 1'b0, 1'b0, 1'b0, D1, 10'd4}, // R7
    '{1'b0, 2'd3, 10'd3, 8'd160, 1'b0, 1'b1, 1'b0, 1'b1, D0, 10'd2}, // R4 R8
    '{1'b0, 2'd1, 10'd2, 8'd180, 1'b1, 1'b0, 1'b1, 1'b0, D1, 10'd5}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_ep = '0;
  logic        tok_in = 1'b0;
  logic        rx_pid_valid = 1'b0;
  logic [3:0]  rx_pid = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_end = 1'b0;
  logic        tx_valid, tx_end, mem_we, ack, nak, done, done_in, ovf;
  logic [7:0]  tx_data, mem_wdata, mem_rdata;
  logic [3:0]  tx_pid;
  logic [31:0] mem_raddr, mem_waddr;
  logic [1:0]  done_ep;

  logic [7:0] bmem [256];
  int n_tx = 0, n_wr = 0, n_done = 0, n_ack = 0, n_nak = 0, n_end = 0;
  logic [7:0] tx_buf [256];
  logic [3:0] tx_pid_buf [256];
  logic [7:0] wr_a [256];
  logic [7:0] wr_d [256];
  logic [1:0] last_ep;
  logic       last_in;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  assign mem_rdata = bmem[mem_raddr[7:0]];

  bd_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .tok_valid_i(tok_valid), .tok_ep_i(tok_ep), .tok_in_i(tok_in),
    .rx_pid_valid_i(rx_pid_valid), .rx_pid_i(rx_pid), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_end_i(rx_end),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_pid_o(tx_pid), .tx_end_o(tx_end),
    .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .ack_o(ack), .nak_o(nak), .done_o(done), .done_ep_o(done_ep), .done_in_o(done_in),
    .ovf_o(ovf)
  );

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && n_tx < 256) begin
        tx_buf[n_tx] = tx_data;
        tx_pid_buf[n_tx] = tx_pid;
        n_tx++;
      end
      if (mem_we && n_wr < 256) begin
        wr_a[n_wr] = mem_waddr[7:0];
        wr_d[n_wr] = mem_wdata;
        bmem[mem_waddr[7:0]] = mem_wdata;
        n_wr++;
      end
      if (done) begin
        n_done++;
        last_ep = done_ep;
        last_in = done_in;
      end
      if (ack) n_ack++;
      if (nak) n_nak++;
      if (tx_end) n_end++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_word(input logic [1:0] ep, input logic din, input logic w, input logic [31:0] d);
    cfg_addr = {ep, din, w};
    cfg_wdata = d;
    cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd_word(input logic [1:0] ep, input logic din, input logic w, output logic [31:0] d);
    cfg_addr = {ep, din, w};
    #2;
    d = cfg_rdata;
  endtask

  task automatic token(input logic [1:0] ep, input logic din);
    tok_ep = ep;
    tok_in = din;
    tok_valid = 1'b1;
    cyc(1);
    tok_valid = 1'b0;
  endtask

  task automatic out_pkt(input logic [3:0] pid, input int nb);
    rx_pid = pid;
    rx_pid_valid = 1'b1;
    cyc(1);
    rx_pid_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rx_data = 8'hC0 + 8'(i);
      rx_valid = 1'b1;
      cyc(1);
    end
    rx_valid = 1'b0;
    rx_end = 1'b1;
    cyc(1);
    rx_end = 1'b0;
  endtask

  function automatic logic [31:0] mk_w0(input vec_t v);
    return (32'(v.cnt) << 16) | 32'h80 | (32'(v.tog) << 6) | (32'(v.keep) << 5) |
           (32'(v.hold) << 4) | (32'(v.chk) << 3);
  endfunction

  initial begin
    logic [31:0] rd;
    bit exp_ovf;
    bit ok;
    int t0, w0c, d0, a0, e0, n0, expn, stored;
    bit mism;
    logic [3:0] epid;
    logic [7:0] ea;
    vec_t v;

    exp_ovf = 1'b0;
    cyc(3);
    // R1 reset state
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd_word(2'(i >> 2), i[1], i[0], rd);
      if (rd != 0) ok = 1'b0;
    end
    chk(ok, "R1 descriptors zero", rd, 0);
    chk(!ovf && !tx_valid && !tx_end && !mem_we && !ack && !nak && !done, "R1 outputs idle",
        {ovf, tx_valid, tx_end, mem_we, ack, nak, done}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 token on unowned descriptor
    wr_word(2'd2, 1'b1, 1'b0, 32'h0004_0040);
    wr_word(2'd2, 1'b1, 1'b1, 32'd20);
    t0 = n_tx; w0c = n_wr; d0 = n_done; n0 = n_nak;
    token(2'd2, 1'b1);
    chk(nak === 1'b1, "R2 nak in cycle after token", 32'(nak), 1);
    cyc(6);
    chk(n_nak - n0 == 1 && n_tx == t0 && n_wr == w0c && n_done == d0, "R2 refused",
        n_nak - n0 + n_tx - t0 + n_done - d0, 1);
    rd_word(2'd2, 1'b1, 1'b0, rd);
    chk(rd == 32'h0004_0040, "R2 descriptor unchanged", rd, 32'h0004_0040);

    // table walk
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      wr_word(v.ep, v.dir_in, 1'b0, mk_w0(v));
      wr_word(v.ep, v.dir_in, 1'b1, 32'(v.addr));
      t0 = n_tx; w0c = n_wr; d0 = n_done; a0 = n_ack; e0 = n_end;
      token(v.ep, v.dir_in);
      epid = v.tog ? D1 : D0;
      mism = !v.dir_in && v.chk && (v.rpid != epid);
      if (v.dir_in) begin
        cyc(int'(v.cnt) + 5);
        ok = (n_tx - t0 == int'(v.cnt));
        for (int i = 0; i < int'(v.cnt); i++) begin
          ea = v.addr + (v.hold ? 8'd0 : 8'(i));
          if (tx_buf[t0 + i] != (ea ^ 8'h5A) || tx_pid_buf[t0 + i] != epid) ok = 1'b0;
        end
        chk(ok, v.hold ? "R4 IN bytes same address" : "R3 IN bytes and pid", n_tx - t0, 32'(v.cnt));
        chk(n_end - e0 == 1 && n_ack == a0, "R3 tx_end once", n_end - e0, 1);
        stored = int'(v.cnt);
      end else begin
        out_pkt(v.rpid, int'(v.nrx));
        cyc(3);
        stored = mism ? 0 : ((v.nrx > v.cnt) ? int'(v.cnt) : int'(v.nrx));
        if (!mism && v.nrx > v.cnt) exp_ovf = 1'b1;
        ok = (n_wr - w0c == stored);
        for (int i = 0; i < stored; i++) begin
          ea = v.addr + (v.hold ? 8'd0 : 8'(i));
          if (wr_a[w0c + i] != ea || wr_d[w0c + i] != 8'hC0 + 8'(i)) ok = 1'b0;
        end
        chk(ok, mism ? "R6 no writes on mismatch" : (v.nrx > v.cnt ? "R9 bytes capped" :
            (v.chk ? "R5 OUT bytes stored" : "R7 OUT stored without check")), n_wr - w0c, stored);
        chk(n_ack - a0 == 1, "R6 ack pulses once", n_ack - a0, 1);
        chk(ovf == exp_ovf, "R9 sticky overflow", 32'(ovf), 32'(exp_ovf));
      end
      rd_word(v.ep, v.dir_in, 1'b0, rd);
      if (v.keep || mism) begin
        chk(rd == mk_w0(v), v.keep ? "R8 descriptor kept" : "R6 descriptor unchanged", rd, mk_w0(v));
        chk(n_done == d0, "R10 no done without release", n_done - d0, 0);
      end else begin
        chk(rd == ((32'(stored) << 16) | (32'(v.tog) << 6) |
                   (32'(v.dir_in ? epid : v.rpid) << 2)), "R5 write-back word",
            rd, (32'(stored) << 16) | (32'(v.tog) << 6) | (32'(v.dir_in ? epid : v.rpid) << 2));
        chk(n_done - d0 == 1 && last_ep == v.ep && last_in == v.dir_in, "R10 done ep dir",
            {n_done - d0, 2'b0, last_ep, 3'b0, last_in}, {1, 2'b0, v.ep, 3'b0, v.dir_in});
      end
    end

    // R8 kept IN descriptor (ep3) serviced again
    t0 = n_tx; d0 = n_done;
    token(2'd3, 1'b1);
    cyc(7);
    chk(n_tx - t0 == 2 && n_done == d0, "R8 kept descriptor serviced again", n_tx - t0, 2);

    // R9 overflow stays set
    cyc(5);
    chk(ovf === 1'b1, "R9 overflow held", 32'(ovf), 1);

    finish_run();
  end
endmodule